// File: doc/BRIEF.md
# Complement-Keyed Protected Control Register

This block holds an 8-bit watchdog control register. Only one kind of write can change it: a keyed write, which carries a data byte and a check byte. The keyed write is accepted only when the check byte is the bitwise inverse of the data byte. A keyed write whose two bytes are not inverses leaves the register as it was. It raises a one-cycle operand-error interrupt and captures the address of the instruction that issued it. Every other kind of write is dropped without any trace.

The stored value drives a run enable and a 2-bit count-clock select, which go to a watchdog counter outside this block. Reads are allowed at any time and change no state. Bits that the register does not define are forced to zero when a value is stored, so a read never returns them set.

Top module: `keyed_ctrl_reg`

## Requirements
- R1: A write with `wrValid` high and `wrKind` = 2'b00 (keyed) whose `wrData` equals `~wrCheck` stores `wrData`, masked to bits 7 and 4:3, at the next clock edge.
- R2: A keyed write whose `wrData` is not `~wrCheck` leaves the register unchanged. It drives `errIrq` high for exactly the one cycle after that write's clock edge.
- R3: On an operand error, `errAddr` takes the `wrAddr` of the faulting write itself. It holds that value until the next operand error.
- R4: Writes with `wrKind` 2'b01 (register move), 2'b10 (AND) or 2'b11 (bit set) leave the register unchanged and never raise `errIrq`, whatever their bytes.
- R5: While `rdEn` is high, `rdData` shows the register value, and a read changes no state. `rdData` is 0 while `rdEn` is low.
- R6: Reset clears the register to 8'h00, `errIrq` to 0 and `errAddr` to 0.
- R7: `runEn` is bit 7 and `clkSel` is bits 4:3 of the register. Bits 6:5 and 2:0 always read as zero.
- R8: A read in the same cycle as an accepted keyed write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write request this cycle |
| wrKind | input | 2 | Write kind: 00 keyed, 01 move, 10 AND, 11 bit set |
| wrData | input | 8 | Data byte |
| wrCheck | input | 8 | Check byte (must equal ~wrData for keyed write) |
| wrAddr | input | ADDR_W (20) | Address of the issuing instruction |
| rdEn | input | 1 | Read enable |
| rdData | output | 8 | Read data |
| runEn | output | 1 | Watchdog run enable |
| clkSel | output | 2 | Watchdog count-clock select |
| errIrq | output | 1 | Operand-error interrupt pulse |
| errAddr | output | ADDR_W (20) | Captured faulting instruction address |

## Verification
The assertions assume that `wrKind`, `wrData`, `wrCheck` and `wrAddr` are stable and known whenever `wrValid` is high at a clock edge. They also assume that reset is applied before the first write. The bench meets both conditions by changing all inputs only on falling edges, after a held reset. It parks `wrValid` low between transactions, so each clock edge sees at most one write. Keyed writes that should fault are driven both with check bytes that differ from the inverse in a single bit and with check bytes equal to the data.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  typedef enum logic [1:0] {
    KIND_KEYED  = 2'b00,
    KIND_MOVE   = 2'b01,
    KIND_AND    = 2'b10,
    KIND_BITSET = 2'b11
  } wrKind_e;

  typedef struct packed {
    logic load;
    logic fault;
  } ctrlStrobes_t;
endpackage

// File: rtl/kcr_ctrl.sv
module kcr_ctrl
  import kcr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [1:0]        wrKind,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrCheck,
  output ctrlStrobes_t      strobes,
  output logic              errIrq
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic isKeyed;
  logic keyMatch;

  assign isKeyed  = wrValid && (wrKind == KIND_KEYED);
  assign keyMatch = (wrData == ~wrCheck);

  always_comb begin
    strobes.load  = isKeyed && keyMatch;
    strobes.fault = isKeyed && !keyMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errIrq <= 1'b0;
    else       errIrq <= strobes.fault;
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.fault));

  // R2
  bad_key_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrKind == 2'b00 && (wrData ^ wrCheck) != ALL_ONES) |=> errIrq);

  // R4
  plain_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrKind != 2'b00) |=> !errIrq);
endmodule

// File: rtl/kcr_datapath.sv
module kcr_datapath
  import kcr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 20,
  parameter int RUN_BIT = 7,
  parameter int SEL_LO  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              runEn,
  output logic [1:0]        clkSel,
  output logic [ADDR_W-1:0] errAddr
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    (DATA_W'(1) << RUN_BIT) | (DATA_W'(3) << SEL_LO);

  logic [DATA_W-1:0] regQ;
  logic [ADDR_W-1:0] errAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regQ <= '0;
    else if (strobes.load) regQ <= wrData & FIELD_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errAddrQ <= '0;
    else if (strobes.fault) errAddrQ <= wrAddr;
  end

  assign rdData  = rdEn ? regQ : '0;
  assign runEn   = regQ[RUN_BIT];
  assign clkSel  = regQ[SEL_LO+1:SEL_LO];
  assign errAddr = errAddrQ;

  // R2
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fault |=> $stable(regQ));

  // R3
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fault |=> (errAddrQ == $past(wrAddr)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fault |=> $stable(errAddrQ));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ((regQ & ~FIELD_MASK) == '0));

  // R5
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(regQ));
endmodule

// File: rtl/keyed_ctrl_reg.sv
module keyed_ctrl_reg
  import kcr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [1:0]        wrKind,
  input  logic [7:0]        wrData,
  input  logic [7:0]        wrCheck,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              runEn,
  output logic [1:0]        clkSel,
  output logic              errIrq,
  output logic [ADDR_W-1:0] errAddr
);
  localparam int DATA_W = 8;

  ctrlStrobes_t strobes;

  kcr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .wrKind  (wrKind),
    .wrData  (wrData),
    .wrCheck (wrCheck),
    .strobes (strobes),
    .errIrq  (errIrq)
  );

  kcr_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RUN_BIT (7),
    .SEL_LO  (3)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .wrAddr  (wrAddr),
    .rdEn    (rdEn),
    .rdData  (rdData),
    .runEn   (runEn),
    .clkSel  (clkSel),
    .errAddr (errAddr)
  );
endmodule

// File: tb/keyed_ctrl_reg_tb.sv
module keyed_ctrl_reg_tb;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [1:0]        wrKind = 2'b00;
  logic [7:0]        wrData = 8'h00;
  logic [7:0]        wrCheck = 8'h00;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic              rdEn = 1'b0;
  logic [7:0]        rdData;
  logic              runEn;
  logic [1:0]        clkSel;
  logic              errIrq;
  logic [ADDR_W-1:0] errAddr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  keyed_ctrl_reg #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrKind(wrKind),
    .wrData(wrData), .wrCheck(wrCheck), .wrAddr(wrAddr), .rdEn(rdEn),
    .rdData(rdData), .runEn(runEn), .clkSel(clkSel), .errIrq(errIrq),
    .errAddr(errAddr)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] exp, input string req);
    rdEn = 1'b1;
    #1;
    check(rdData == exp, req, "rdData", 32'(rdData), 32'(exp));
    rdEn = 1'b0;
    #1;
    check(rdData == 8'h00, "R5", "rdData idle", 32'(rdData), 0);
  endtask

  // One write transaction: drive at a falling edge, clear at the next.
  task automatic doWrite(input logic [1:0] kind, input logic [7:0] d,
                         input logic [7:0] c, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wrValid = 1'b1; wrKind = kind; wrData = d; wrCheck = c; wrAddr = a;
    @(negedge clk);
    wrValid = 1'b0; wrKind = 2'b00; wrData = 8'h00; wrCheck = 8'h00; wrAddr = '0;
  endtask

  task automatic testReset();
    readReg(8'h00, "R6");
    check(runEn == 1'b0, "R6", "runEn", 32'(runEn), 0);
    check(clkSel == 2'b00, "R6", "clkSel", 32'(clkSel), 0);
    check(errIrq == 1'b0, "R6", "errIrq", 32'(errIrq), 0);
    check(errAddr == '0, "R6", "errAddr", 32'(errAddr), 0);
  endtask

  task automatic testGoodWrites();
    doWrite(2'b00, 8'h98, 8'h67, 20'h00100);
    readReg(8'h98, "R1");
    check(runEn == 1'b1, "R7", "runEn", 32'(runEn), 1);
    check(clkSel == 2'b11, "R7", "clkSel", 32'(clkSel), 3);
    check(errIrq == 1'b0, "R1", "errIrq", 32'(errIrq), 0);
    doWrite(2'b00, 8'hFF, 8'h00, 20'h00104);
    readReg(8'h98, "R7");
    doWrite(2'b00, 8'h10, 8'hEF, 20'h00108);
    readReg(8'h10, "R1");
    check(runEn == 1'b0, "R7", "runEn", 32'(runEn), 0);
    check(clkSel == 2'b10, "R7", "clkSel", 32'(clkSel), 2);
  endtask

  task automatic testBadKey();
    doWrite(2'b00, 8'h88, 8'h76, 20'h01234);
    check(errIrq == 1'b1, "R2", "errIrq pulse", 32'(errIrq), 1);
    check(errAddr == 20'h01234, "R3", "errAddr", 32'(errAddr), 32'h01234);
    readReg(8'h10, "R2");
    @(negedge clk);
    check(errIrq == 1'b0, "R2", "errIrq after pulse", 32'(errIrq), 0);
    doWrite(2'b00, 8'h55, 8'h55, 20'hABCDE);
    check(errIrq == 1'b1, "R2", "errIrq equal bytes", 32'(errIrq), 1);
    check(errAddr == 20'hABCDE, "R3", "errAddr update", 32'(errAddr), 32'hABCDE);
    readReg(8'h10, "R2");
    doWrite(2'b00, 8'h80, 8'h7F, 20'h00200);
    readReg(8'h80, "R1");
    check(errAddr == 20'hABCDE, "R3", "errAddr held", 32'(errAddr), 32'hABCDE);
  endtask

  task automatic testOtherKinds();
    for (int k = 1; k < 4; k++) begin
      doWrite(2'(k), 8'h18, 8'hE7, 20'h00300);
      check(errIrq == 1'b0, "R4", "errIrq", 32'(errIrq), 0);
      readReg(8'h80, "R4");
      doWrite(2'(k), 8'h00, 8'h00, 20'h00304);
      check(errIrq == 1'b0, "R4", "errIrq bad bytes", 32'(errIrq), 0);
    end
    check(errAddr == 20'hABCDE, "R4", "errAddr", 32'(errAddr), 32'hABCDE);
  endtask

  task automatic testSameCycleRead();
    @(negedge clk);
    wrValid = 1'b1; wrKind = 2'b00; wrData = 8'h08; wrCheck = 8'hF7; rdEn = 1'b1;
    #1;
    check(rdData == 8'h80, "R8", "read with write", 32'(rdData), 32'h80);
    @(negedge clk);
    wrValid = 1'b0; rdEn = 1'b0;
    readReg(8'h08, "R8");
  endtask

  task automatic testReadNoEffect();
    @(negedge clk);
    rdEn = 1'b1;
    repeat (3) @(negedge clk);
    check(rdData == 8'h08, "R5", "repeated read", 32'(rdData), 32'h08);
    check(errIrq == 1'b0, "R5", "errIrq", 32'(errIrq), 0);
    rdEn = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGoodWrites();
    testBadKey();
    testOtherKinds();
    testSameCycleRead();
    testReadNoEffect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule